// File: doc/BRIEF.md
# Element-indexed vector register file

This block is a register file of 128 registers, 64 bits each, that can also be addressed as a packed array of vector elements. Every access gives a base register, an element index and an element width of 8, 16, 32 or 64 bits. The storage is treated as one flat byte array in little-endian order. Element 0 starts at byte 0 of the base register. Higher-numbered elements follow directly, so narrow elements are packed several to a register. Once an index runs past the end of the base register, the element lies in the next higher-numbered registers.

The block has one synchronous write port and two combinational read ports. A write enables only the byte lanes that its element covers, so the other bytes of that register keep their values. A read returns the element zero-extended to 64 bits. Width code 00 selects 64-bit elements, which makes an access with index 0 an ordinary scalar register access. Any access whose element lies beyond the last register raises an error flag on its port. For a write, that flag also blocks the store.

Top module: `vrf_elem_rf`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every byte of storage becomes zero. After reset, every in-range read returns 0.
- R2: The width code selects the element size: 00 = 64 bits, 01 = 32, 10 = 16, 11 = 8. The byte offset of an element is base*8 + index*(element bytes). The register it lies in is offset/8, and its lowest byte lane is offset mod 8. Byte k of the element is lane (offset mod 8)+k, which is bits 8*lane+7..8*lane of the register (little-endian).
- R3: An element whose offset reaches past byte 7 of the base register lies in a higher-numbered register. For example, base 5 with index 9 at 8-bit width is register 6, lane 1.
- R4: A write of an element narrower than 64 bits changes only that element's byte lanes. All other bytes of the register keep their previous values.
- R5: At 64-bit width, index i addresses the whole of register base+i, so index 0 is a plain scalar access.
- R6: A read of a narrow element returns it zero-extended: every bit above the element width is 0.
- R7: When offset/8 is 128 or more, the port's error output is 1 and its read data is 0. A write with this error changes no storage.
- R8: A write takes effect at the rising clock edge. In the cycle of the write, a read of the same bytes returns the old contents, and from the next cycle on it returns the new ones.
- R9: The two read ports are independent. Each one decodes its own base, index and width in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes on rising edge |
| rst_n | input | 1 | Synchronous active-low reset, clears storage |
| wr_en | input | 1 | Write request |
| wr_base | input | 7 | Write base register |
| wr_idx | input | 10 | Write element index |
| wr_width | input | 2 | Write element width code |
| wr_data | input | 64 | Write element value in the low bits |
| wr_err | output | 1 | Write element lies beyond the last register |
| rd0_base | input | 7 | Read port 0 base register |
| rd0_idx | input | 10 | Read port 0 element index |
| rd0_width | input | 2 | Read port 0 element width code |
| rd0_data | output | 64 | Read port 0 element, zero-extended |
| rd0_err | output | 1 | Read port 0 element out of range |
| rd1_base | input | 7 | Read port 1 base register |
| rd1_idx | input | 10 | Read port 1 element index |
| rd1_width | input | 2 | Read port 1 element width code |
| rd1_data | output | 64 | Read port 1 element, zero-extended |
| rd1_err | output | 1 | Read port 1 element out of range |

## Verification
Directed patterns come first:
- A narrow element written into a register that is already full of data shows whether the neighbouring lanes survive.
- The same bytes are read back at a different width, which tells lane placement apart from byte order.
- Indices that run past the base register show that the element spills into the next register rather than wrapping within the base.
- Accesses at the last register and one element past it mark the exact error boundary, including a write that must be dropped.
- A read in the same cycle as a write to the same bytes separates old data from new data.

A long random mix of widths, bases and indices is then run with a small base range, so that reads often overlap earlier writes. Every cycle, the random mix is compared against a byte-array model on both read ports and all three error flags.

// File: rtl/vrf_pkg.sv
// Shared definitions for the element-indexed register file.
// Assumes byte-granular storage of 64-bit rows.
package vrf_pkg;
    typedef enum logic [1:0] {
        EW64 = 2'b00,
        EW32 = 2'b01,
        EW16 = 2'b10,
        EW8  = 2'b11
    } ew_e;

    localparam int unsigned ROW_BYTES = 8;
    localparam int unsigned ROW_BITS  = 64;
endpackage

// File: rtl/vrf_elem_map.sv
// Maps (base, index, width) to a row, a lowest byte lane, byte enables and a
// range error. Elements are aligned to their own size, so an element never
// straddles two rows. The clock and reset are used only by the assertions.
module vrf_elem_map #(
    parameter int unsigned NREG  = 128,
    parameter int unsigned IDX_W = 10,
    localparam int unsigned REG_W = $clog2(NREG),
    localparam int unsigned OFF_W = REG_W + IDX_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] base,
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       width,
    output logic [REG_W-1:0] row,
    output logic [2:0]       lane,
    output logic [7:0]       be,
    output logic             err
);
    import vrf_pkg::*;

    logic [OFF_W-1:0] off;
    logic [OFF_W-4:0] row_full;
    logic [7:0]       size_mask;
    logic [1:0]       shamt;

    // Byte offset of the element inside the flat byte array.
    always_comb begin
        shamt = 2'd3 - width;
        off   = (OFF_W'(base) << 3) + (OFF_W'(idx) << shamt);
    end

    // Row number, lane and range check derived from the byte offset.
    always_comb begin
        row_full = off[OFF_W-1:3];
        err      = (row_full >= (OFF_W-3)'(NREG));
        row      = row_full[REG_W-1:0];
        lane     = off[2:0];
    end

    // Byte-lane enables covering the element's bytes.
    always_comb begin
        case (ew_e'(width))
            EW64:    size_mask = 8'hFF;
            EW32:    size_mask = 8'h0F;
            EW16:    size_mask = 8'h03;
            default: size_mask = 8'h01;
        endcase
        be = err ? 8'h00 : (size_mask << lane);
    end

    // R2: enables are contiguous, element-sized and aligned to the element size.
    p_lane_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !err |-> (((be >> lane) & 8'h01) == 8'h01) &&
                 ($countones(be) == (1 << (3 - width))));

    // R5: a 64-bit element is the whole row base+index.
    p_scalar_row_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (width == 2'b00) && !err |-> (lane == 3'd0) &&
                                     (row == REG_W'(base + REG_W'(idx))));
endmodule

// File: rtl/vrf_lane_extract.sv
// Pulls one element out of a raw 64-bit row at a given lane and width.
// The element is zero-extended, and the result is forced to zero when the
// access is out of range. The clock and reset are used only by the assertions.
module vrf_lane_extract (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] raw,
    input  logic [2:0]  lane,
    input  logic [1:0]  width,
    input  logic        err,
    output logic [63:0] data
);
    import vrf_pkg::*;

    logic [63:0] shifted;
    logic [63:0] keep;

    // Right-align the element and mask off the bits above its width.
    always_comb begin
        shifted = raw >> {lane, 3'b000};
        case (ew_e'(width))
            EW64:    keep = 64'hFFFF_FFFF_FFFF_FFFF;
            EW32:    keep = 64'h0000_0000_FFFF_FFFF;
            EW16:    keep = 64'h0000_0000_0000_FFFF;
            default: keep = 64'h0000_0000_0000_00FF;
        endcase
        data = err ? 64'd0 : (shifted & keep);
    end

    // R6: an 8-bit element never carries bits above bit 7.
    p_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (width == 2'b11) |-> (data[63:8] == 56'd0));
endmodule

// File: rtl/vrf_byte_store.sv
// Backing storage: NREG rows of 64 bits, with byte-enabled synchronous write
// and two combinational raw-row read ports. A read in the cycle of a write
// sees the old row. A synchronous active-low reset clears all rows.
module vrf_byte_store #(
    parameter int unsigned NREG = 128,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wrow,
    input  logic [7:0]       wbe,
    input  logic [63:0]      wdata,
    input  logic [REG_W-1:0] rrow0,
    input  logic [REG_W-1:0] rrow1,
    output logic [63:0]      rdat0,
    output logic [63:0]      rdat1
);
    logic [63:0] mem [NREG];
    logic [63:0] cur_wrow;
    logic [63:0] be_bits;

    // Combinational reads of raw rows, plus the row under write for the checks.
    always_comb begin
        rdat0    = mem[rrow0];
        rdat1    = mem[rrow1];
        cur_wrow = mem[wrow];
        for (int b = 0; b < 8; b++) begin
            be_bits[8*b +: 8] = {8{wbe[b]}};
        end
    end

    // Clear on reset, else update only the enabled byte lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREG; r++) begin
                mem[r] <= 64'd0;
            end
        end else if (we) begin
            for (int b = 0; b < 8; b++) begin
                if (wbe[b]) begin
                    mem[wrow][8*b +: 8] <= wdata[8*b +: 8];
                end
            end
        end
    end

    // R4: bytes outside the enables keep their old value.
    p_lanes_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (((mem[$past(wrow)] ^ $past(cur_wrow)) & ~$past(be_bits)) == 64'd0));

    // R8: enabled bytes hold the written value one edge later.
    p_lanes_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((mem[$past(wrow)] & $past(be_bits)) == ($past(wdata) & $past(be_bits))));
endmodule

// File: rtl/vrf_elem_rf.sv
// Element-indexed register file top. Three address maps (one write, two read)
// turn (base, index, width) into a row, a lane and byte enables. Write data is
// moved to its lane, and an out-of-range write is dropped. Each read row is
// aligned and zero-extended by its own extractor.
module vrf_elem_rf #(
    parameter int unsigned NREG  = 128,
    parameter int unsigned IDX_W = 10,
    localparam int unsigned REG_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_base,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [1:0]       wr_width,
    input  logic [63:0]      wr_data,
    output logic             wr_err,
    input  logic [REG_W-1:0] rd0_base,
    input  logic [IDX_W-1:0] rd0_idx,
    input  logic [1:0]       rd0_width,
    output logic [63:0]      rd0_data,
    output logic             rd0_err,
    input  logic [REG_W-1:0] rd1_base,
    input  logic [IDX_W-1:0] rd1_idx,
    input  logic [1:0]       rd1_width,
    output logic [63:0]      rd1_data,
    output logic             rd1_err
);
    localparam int unsigned NRD = 2;

    logic [REG_W-1:0] w_row;
    logic [2:0]       w_lane;
    logic [7:0]       w_be;
    logic [63:0]      w_data_sh;
    logic             st_we;

    logic [REG_W-1:0] r_base  [NRD];
    logic [IDX_W-1:0] r_idx   [NRD];
    logic [1:0]       r_width [NRD];
    logic [REG_W-1:0] r_row   [NRD];
    logic [2:0]       r_lane  [NRD];
    logic [7:0]       r_be    [NRD];
    logic             r_err   [NRD];
    logic [63:0]      r_raw   [NRD];
    logic [63:0]      r_data  [NRD];

    vrf_elem_map #(.NREG(NREG), .IDX_W(IDX_W)) u_wmap (
        .clk   (clk),
        .rst_n (rst_n),
        .base  (wr_base),
        .idx   (wr_idx),
        .width (wr_width),
        .row   (w_row),
        .lane  (w_lane),
        .be    (w_be),
        .err   (wr_err)
    );

    // Move the write element into its lane, and drop an out-of-range write.
    always_comb begin
        w_data_sh = wr_data << {w_lane, 3'b000};
        st_we     = wr_en && !wr_err;
    end

    // Gather the read-port inputs into arrays for the per-port generate.
    always_comb begin
        r_base[0]  = rd0_base;
        r_idx[0]   = rd0_idx;
        r_width[0] = rd0_width;
        r_base[1]  = rd1_base;
        r_idx[1]   = rd1_idx;
        r_width[1] = rd1_width;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        logic [7:0] unused_be;

        vrf_elem_map #(.NREG(NREG), .IDX_W(IDX_W)) u_rmap (
            .clk   (clk),
            .rst_n (rst_n),
            .base  (r_base[p]),
            .idx   (r_idx[p]),
            .width (r_width[p]),
            .row   (r_row[p]),
            .lane  (r_lane[p]),
            .be    (r_be[p]),
            .err   (r_err[p])
        );

        vrf_lane_extract u_ext (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (r_raw[p]),
            .lane  (r_lane[p]),
            .width (r_width[p]),
            .err   (r_err[p]),
            .data  (r_data[p])
        );

        // Read enables only feed the check that flags out-of-range reads.
        always_comb unused_be = r_be[p];

        // R7: an out-of-range read has no enabled lane and returns zero.
        p_rd_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            r_err[p] |-> (unused_be == 8'h00) && (r_data[p] == 64'd0));
    end

    vrf_byte_store #(.NREG(NREG)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (st_we),
        .wrow  (w_row),
        .wbe   (w_be),
        .wdata (w_data_sh),
        .rrow0 (r_row[0]),
        .rrow1 (r_row[1]),
        .rdat0 (r_raw[0]),
        .rdat1 (r_raw[1])
    );

    // Drive the read-port outputs.
    always_comb begin
        rd0_data = r_data[0];
        rd0_err  = r_err[0];
        rd1_data = r_data[1];
        rd1_err  = r_err[1];
    end

    // R7: a write flagged out of range enables no byte lane.
    p_wr_err_nolane_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err |-> (w_be == 8'h00));
endmodule

// File: tb/vrf_elem_rf_test.sv
// Self-checking bench: a flat byte-array model, updated behaviourally and
// compared with all read and error outputs in every driven cycle.
module vrf_elem_rf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_base = '0;
    logic [9:0]  wr_idx = '0;
    logic [1:0]  wr_width = '0;
    logic [63:0] wr_data = '0;
    logic        wr_err;
    logic [6:0]  rd0_base = '0, rd1_base = '0;
    logic [9:0]  rd0_idx = '0, rd1_idx = '0;
    logic [1:0]  rd0_width = '0, rd1_width = '0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_err, rd1_err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] model [1024];

    always #5 clk = ~clk;

    vrf_elem_rf uut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx), .wr_width(wr_width),
        .wr_data(wr_data), .wr_err(wr_err),
        .rd0_base(rd0_base), .rd0_idx(rd0_idx), .rd0_width(rd0_width),
        .rd0_data(rd0_data), .rd0_err(rd0_err),
        .rd1_base(rd1_base), .rd1_idx(rd1_idx), .rd1_width(rd1_width),
        .rd1_data(rd1_data), .rd1_err(rd1_err)
    );

    function automatic int nbytes(logic [1:0] w);
        return 8 >> w;
    endfunction

    function automatic int offset_of(logic [6:0] b, logic [9:0] i, logic [1:0] w);
        return int'(b) * 8 + int'(i) * nbytes(w);
    endfunction

    function automatic bit oor(logic [6:0] b, logic [9:0] i, logic [1:0] w);
        return (offset_of(b, i, w) / 8) >= 128;
    endfunction

    function automatic logic [63:0] model_read(logic [6:0] b, logic [9:0] i, logic [1:0] w);
        logic [63:0] v = '0;
        int off = offset_of(b, i, w);
        if (oor(b, i, w)) return '0;
        for (int k = 0; k < nbytes(w); k++) v[8*k +: 8] = model[off + k];
        return v;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle: drive, compare the combinational outputs, then commit the model.
    task automatic step(string tag, bit we, logic [6:0] wb, logic [9:0] wi,
                        logic [1:0] ww, logic [63:0] wd,
                        logic [6:0] b0, logic [9:0] i0, logic [1:0] w0,
                        logic [6:0] b1, logic [9:0] i1, logic [1:0] w1);
        @(negedge clk);
        wr_en = we; wr_base = wb; wr_idx = wi; wr_width = ww; wr_data = wd;
        rd0_base = b0; rd0_idx = i0; rd0_width = w0;
        rd1_base = b1; rd1_idx = i1; rd1_width = w1;
        #1;
        check({tag, " rd0_data"}, rd0_data, model_read(b0, i0, w0));
        check({tag, " rd1_data"}, rd1_data, model_read(b1, i1, w1));
        check({tag, " rd0_err"}, {63'd0, rd0_err}, {63'd0, oor(b0, i0, w0)});
        check({tag, " rd1_err"}, {63'd0, rd1_err}, {63'd0, oor(b1, i1, w1)});
        check({tag, " wr_err"}, {63'd0, wr_err}, {63'd0, oor(wb, wi, ww)});
        if (we && !oor(wb, wi, ww)) begin
            int off = offset_of(wb, wi, ww);
            for (int k = 0; k < nbytes(ww); k++) model[off + k] = wd[8*k +: 8];
        end
    endtask

    task automatic rd(string tag, logic [6:0] b0, logic [9:0] i0, logic [1:0] w0,
                      logic [6:0] b1, logic [9:0] i1, logic [1:0] w1);
        step(tag, 1'b0, 7'd0, 10'd0, 2'd0, 64'd0, b0, i0, w0, b1, i1, w1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 1024; k++) model[k] = 8'h00;
    endtask

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        rd("R1 reset", 7'd0, 10'd0, 2'd0, 7'd127, 10'd0, 2'd0);
        rd("R1 reset", 7'd40, 10'd3, 2'd3, 7'd9, 10'd1, 2'd1);

        // R5: scalar writes and reads of whole rows
        step("R5 scalar", 1'b1, 7'd3, 10'd0, 2'd0, 64'h1122_3344_5566_7788,
             7'd3, 10'd0, 2'd0, 7'd2, 10'd1, 2'd0);
        step("R5 scalar", 1'b1, 7'd4, 10'd0, 2'd0, 64'hA5A5_5A5A_F0F0_0F0F,
             7'd2, 10'd1, 2'd0, 7'd0, 10'd4, 2'd0);
        // R2: little-endian lanes seen at other widths
        rd("R2 lanes", 7'd3, 10'd1, 2'd1, 7'd3, 10'd5, 2'd3);
        rd("R2 lanes", 7'd3, 10'd2, 2'd2, 7'd3, 10'd0, 2'd3);
        // R4 and R6: narrow writes keep neighbours, reads zero-extended
        step("R4 narrow", 1'b1, 7'd3, 10'd2, 2'd3, 64'hFFFF_FFFF_FFFF_FFEE,
             7'd3, 10'd0, 2'd0, 7'd3, 10'd2, 2'd3);
        rd("R4 keep", 7'd3, 10'd0, 2'd0, 7'd3, 10'd1, 2'd2);
        step("R6 zext", 1'b1, 7'd4, 10'd1, 2'd2, 64'hDEAD_BEEF_CAFE_8001,
             7'd4, 10'd0, 2'd0, 7'd4, 10'd1, 2'd2);
        rd("R6 zext", 7'd4, 10'd1, 2'd2, 7'd4, 10'd0, 2'd1);
        // R3: spill into following rows
        step("R3 spill", 1'b1, 7'd5, 10'd9, 2'd3, 64'h0000_0000_0000_007C,
             7'd6, 10'd0, 2'd0, 7'd6, 10'd1, 2'd3);
        rd("R3 spill", 7'd6, 10'd0, 2'd0, 7'd5, 10'd9, 2'd3);
        step("R3 spill", 1'b1, 7'd10, 10'd5, 2'd1, 64'h0000_0000_1357_9BDF,
             7'd12, 10'd1, 2'd1, 7'd12, 10'd0, 2'd0);
        rd("R3 spill", 7'd12, 10'd1, 2'd1, 7'd12, 10'd0, 2'd0);
        // R7: boundary at the last row and one element past it
        step("R7 last", 1'b1, 7'd127, 10'd7, 2'd3, 64'h0000_0000_0000_0099,
             7'd127, 10'd0, 2'd0, 7'd127, 10'd8, 2'd3);
        step("R7 drop", 1'b1, 7'd127, 10'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF,
             7'd127, 10'd0, 2'd0, 7'd0, 10'd1023, 2'd0);
        step("R7 drop", 1'b1, 7'd0, 10'd1023, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF,
             7'd127, 10'd0, 2'd0, 7'd0, 10'd1023, 2'd3);
        rd("R7 drop", 7'd127, 10'd0, 2'd0, 7'd0, 10'd0, 2'd0);
        // R8: same-cycle read sees old data, next cycle new
        step("R8 old", 1'b1, 7'd20, 10'd0, 2'd0, 64'h0BAD_F00D_1234_5678,
             7'd20, 10'd0, 2'd0, 7'd20, 10'd1, 2'd1);
        rd("R8 new", 7'd20, 10'd0, 2'd0, 7'd20, 10'd1, 2'd1);
        // R9: two ports at different widths and bases in one cycle
        rd("R9 ports", 7'd3, 10'd0, 2'd0, 7'd4, 10'd3, 2'd2);

        // R2: random mix across widths, bases and indices
        for (int n = 0; n < 4000; n++) begin
            logic [1:0] ww = 2'($urandom);
            logic [1:0] w0 = 2'($urandom);
            logic [1:0] w1 = 2'($urandom);
            logic [6:0] wb = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 16);
            logic [6:0] b0 = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 16);
            logic [6:0] b1 = 7'($urandom % 16);
            logic [9:0] wi = 10'($urandom % 40);
            logic [9:0] i0 = 10'($urandom % 40);
            logic [9:0] i1 = ($urandom % 16 == 0) ? 10'($urandom) : 10'($urandom % 40);
            step("R2 random", 1'($urandom), wb, wi, ww, {$urandom, $urandom},
                 b0, i0, w0, b1, i1, w1);
        end

        // R1: reset after traffic clears everything
        do_reset();
        rd("R1 reclear", 7'd3, 10'd0, 2'd0, 7'd6, 10'd0, 2'd0);
        rd("R1 reclear", 7'd12, 10'd1, 2'd1, 7'd127, 10'd7, 2'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule